// File: doc/BRIEF.md
# Nibble Serial Port with Gated Serial Clock

This block is the serial input/output register of a small controller core. It holds a 4-bit register that works in one of two modes. In shift mode it moves its contents one place to the left at the start of every instruction cycle and takes the serial input into its lowest bit. In count mode it adds one to its contents on every falling transition seen on the serial input. An exchange command, issued at the midpoint of an instruction cycle, swaps the register with the accumulator value offered by the core. The previous register contents come back on a read-back port. The same command loads a clock-enable latch from the carry bit.

The serial clock is the instruction-cycle rhythm gated by that latch. In shift mode, with the latch set, the clock pin rises at each cycle start and falls at each midpoint. In count mode it sits steadily at the latch value. The serial data output carries the register's top bit as captured at each midpoint, and it is forced low whenever the output-enable bit is clear. The core supplies two free-running strobes, one at the start and one at the midpoint of each instruction cycle. It can keep a continuous bit stream going by issuing an exchange every fourth cycle.

Top module: `nsp_port`

## Requirements
- R1: In shift mode (`mode_cnt`=0), on every clock edge where `cyc_start` is high, the register moves left by one place and takes `si` into bit 0.
- R2: `so` is 0 in any cycle where `so_en` is 0. With `so_en`=1, `so` shows the register's bit 3 as captured on the most recent clock edge where `cyc_mid` was high.
- R3: On a clock edge where `xchg` and `cyc_mid` are both high, the register loads `acc_in`, `rd_out` takes the register's previous contents, and from that edge `so` shows `acc_in` bit 3 (with `so_en`=1).
- R4: An `xchg` pulse on a clock edge where `cyc_mid` is low has no effect on the register, on `rd_out` or on the clock-enable latch.
- R5: An exchange copies `carry_in` into the clock-enable latch. In shift mode, with the latch set, `sk` goes high on each `cyc_start` edge and low on each `cyc_mid` edge. With the latch clear, `sk` stays low.
- R6: In count mode (`mode_cnt`=1), `sk` equals the latch value one clock later, regardless of the strobes. It is held steadily high while the latch is set and steadily low while it is clear.
- R7: Changing from count mode to shift mode while the latch is set resumes the pulses on `sk` from the next cycle start, with no new exchange.
- R8: With an exchange at the midpoint of every fourth cycle, `rd_out` after an exchange equals the four `si` bits sampled at the four preceding cycle starts. The earliest bit ends up in bit 3 and the latest in bit 0.
- R9: In count mode, each 1-to-0 change of `si` between consecutive clocks adds one to the register, modulo 16. Rising changes and strobes leave it unchanged, and an exchange on the same edge takes priority.
- R10: A clock edge with `rst` high clears the register, the latch, `sk`, `so` and `rd_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | One-clock strobe at the start of each instruction cycle |
| cyc_mid | input | 1 | One-clock strobe at the midpoint of each instruction cycle |
| xchg | input | 1 | Exchange command, acted on only together with `cyc_mid` |
| acc_in | input | 4 | Accumulator value loaded into the register on an exchange |
| carry_in | input | 1 | Value loaded into the clock-enable latch on an exchange |
| mode_cnt | input | 1 | 0 = shift mode, 1 = count mode |
| so_en | input | 1 | 1 lets the register's top bit reach `so`, 0 forces `so` low |
| si | input | 1 | Serial data input |
| sk | output | 1 | Gated serial clock |
| so | output | 1 | Serial data output |
| rd_out | output | 4 | Register contents returned by the latest exchange |

## Verification
The register, `sk`, the captured top bit and `rd_out` are all registered, so each result is due one clock after the strobe or exchange edge that causes it. The gating on `so` by `so_en` acts within the same cycle. The bench drives every input just after a rising edge and reads the outputs 1 ns after the following edge. It records `sk` after the cycle-start edge, and `sk`, `so` and `rd_out` after the midpoint edge, of each 8-clock instruction cycle. The register itself is never read directly; its contents are inferred through `so` and through the value that the next exchange returns.

// File: rtl/nsp_pkg.sv
`timescale 1ns/1ps
package nsp_pkg;

    localparam int unsigned NSP_NIBBLE = 4;

    typedef enum logic {
        NSP_SHIFT = 1'b0,
        NSP_COUNT = 1'b1
    } nsp_mode_e;

    // per-clock timing events seen by the datapath
    typedef struct packed {
        logic start;   // instruction cycle begins
        logic mid;     // instruction cycle midpoint
        logic xfer;    // qualified exchange (command at midpoint)
    } nsp_evt_t;

endpackage

// File: rtl/nsp_edge.sv
`timescale 1ns/1ps
module nsp_edge (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic din_q;

    always_ff @(posedge clk) begin
        if (rst) din_q <= 1'b0;
        else     din_q <= din;
    end

    assign fall = din_q & ~din;

endmodule

// File: rtl/nsp_skgen.sv
`timescale 1ns/1ps
module nsp_skgen
    import nsp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  nsp_evt_t  evt,
    input  nsp_mode_e mode,
    input  logic      carry,
    output logic      sk
);
    logic gate_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= 1'b0;
            sk     <= 1'b0;
        end else begin
            if (evt.xfer) gate_q <= carry;
            if (mode == NSP_COUNT)  sk <= gate_q;
            else if (evt.start)     sk <= gate_q;
            else if (evt.mid)       sk <= 1'b0;
        end
    end

    // R5: shift-mode clock always drops at the midpoint
    p_mid_low_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.mid && mode == NSP_SHIFT) |=> !sk);

    // R6: count mode holds the clock high while the latch is set
    p_steady_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == NSP_COUNT && gate_q && !evt.xfer) |=> sk);

    // R5: a cleared latch keeps the shift-mode clock low at cycle start
    p_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.start && mode == NSP_SHIFT && !gate_q) |=> !sk);

endmodule

// File: rtl/nsp_sio.sv
`timescale 1ns/1ps
module nsp_sio
    import nsp_pkg::*;
#(
    parameter int unsigned W = NSP_NIBBLE
) (
    input  logic         clk,
    input  logic         rst,
    input  nsp_evt_t     evt,
    input  nsp_mode_e    mode,
    input  logic [W-1:0] acc,
    input  logic         si,
    input  logic         si_fall,
    output logic [W-1:0] rd,
    output logic         msb
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
            rd   <= '0;
        end else if (evt.xfer) begin
            sr_q <= acc;
            rd   <= sr_q;
        end else if (mode == NSP_SHIFT && evt.start) begin
            sr_q <= {sr_q[W-2:0], si};
        end else if (mode == NSP_COUNT && si_fall) begin
            sr_q <= sr_q + ONE;
        end
    end

    // top bit captured at the midpoint; an exchange there presents the new value
    always_ff @(posedge clk) begin
        if (rst)          msb <= 1'b0;
        else if (evt.mid) msb <= evt.xfer ? acc[W-1] : sr_q[W-1];
    end

    // R1: shift at cycle start
    p_shift_r1: assert property (@(posedge clk) disable iff (rst)
        (evt.start && !evt.xfer && mode == NSP_SHIFT)
        |=> sr_q == {$past(sr_q[W-2:0]), $past(si)});

    // R3: exchange loads accumulator and returns old contents
    p_load_r3: assert property (@(posedge clk) disable iff (rst)
        evt.xfer |=> (sr_q == $past(acc)) && (rd == $past(sr_q)));

    // R9: count on falling SI
    p_count_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == NSP_COUNT && si_fall && !evt.xfer)
        |=> sr_q == $past(sr_q) + ONE);

    // R9: no falling SI, no count
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == NSP_COUNT && !si_fall && !evt.xfer) |=> $stable(sr_q));

endmodule

// File: rtl/nsp_port.sv
`timescale 1ns/1ps
module nsp_port
    import nsp_pkg::*;
#(
    parameter int unsigned W = NSP_NIBBLE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cyc_start,
    input  logic         cyc_mid,
    input  logic         xchg,
    input  logic [W-1:0] acc_in,
    input  logic         carry_in,
    input  logic         mode_cnt,
    input  logic         so_en,
    input  logic         si,
    output logic         sk,
    output logic         so,
    output logic [W-1:0] rd_out
);
    nsp_evt_t  evt;
    nsp_mode_e mode;
    logic      si_fall;
    logic      msb;

    assign evt.start = cyc_start;
    assign evt.mid   = cyc_mid;
    assign evt.xfer  = xchg & cyc_mid;
    assign mode      = nsp_mode_e'(mode_cnt);

    nsp_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (si),
        .fall (si_fall)
    );

    nsp_skgen u_skgen (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .mode  (mode),
        .carry (carry_in),
        .sk    (sk)
    );

    nsp_sio #(.W(W)) u_sio (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .mode    (mode),
        .acc     (acc_in),
        .si      (si),
        .si_fall (si_fall),
        .rd      (rd_out),
        .msb     (msb)
    );

    assign so = so_en & msb;

    // R4: exchange outside the midpoint leaves the read-back untouched
    p_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (xchg && !cyc_mid) |=> $stable(rd_out));

    // R10: reset clears the pins and the read-back
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!sk && !so && rd_out == '0));

endmodule

// File: tb/test_nsp_port.sv
`timescale 1ns/1ps
module test_nsp_port;

    logic       clk = 1'b0;
    logic       rst, cyc_start, cyc_mid, xchg, carry_in, mode_cnt, so_en, si;
    logic [3:0] acc_in;
    logic       sk, so;
    logic [3:0] rd_out;

    int   n_chk = 0;
    int   n_err = 0;
    logic done = 1'b0;

    // observations of one instruction cycle
    logic       sk_s, sk_m, so_m, sk_any, sk_all;
    logic [3:0] rd_m, prev, pat, nxt;

    always #2.5 clk = ~clk;

    nsp_port i_nsp_port (
        .clk(clk), .rst(rst), .cyc_start(cyc_start), .cyc_mid(cyc_mid),
        .xchg(xchg), .acc_in(acc_in), .carry_in(carry_in), .mode_cnt(mode_cnt),
        .so_en(so_en), .si(si), .sk(sk), .so(so), .rd_out(rd_out)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one 8-clock instruction cycle: start strobe at clock 0, midpoint at clock 4
    task automatic run_cyc(input logic si_b, input logic x, input logic [3:0] a,
                           input logic c, input int xp);
        sk_any = 1'b0;
        sk_all = 1'b1;
        for (int p = 0; p < 8; p++) begin
            cyc_start = (p == 0);
            cyc_mid   = (p == 4);
            xchg      = x && (p == xp);
            acc_in    = a;
            carry_in  = c;
            si        = si_b;
            step();
            sk_any = sk_any | sk;
            sk_all = sk_all & sk;
            if (p == 0) sk_s = sk;
            if (p == 4) begin
                sk_m = sk;
                so_m = so;
                rd_m = rd_out;
            end
        end
        cyc_start = 1'b0;
        cyc_mid   = 1'b0;
        xchg      = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cyc_start = 0; cyc_mid = 0; xchg = 0; acc_in = '0;
        carry_in = 0; mode_cnt = 0; so_en = 1; si = 0;
        step(); step(); step();
        chk("R10 sk after reset", {3'b0, sk}, 4'd0);
        chk("R10 so after reset", {3'b0, so}, 4'd0);
        chk("R10 rd_out after reset", rd_out, 4'd0);
        rst = 1'b0;

        // R1: shift 1,0,0,0 into a cleared register; the 1 reaches bit 3 on the fourth shift
        run_cyc(1'b1, 1'b0, 4'h0, 1'b0, 4);
        chk("R10 latch clear, no sk pulse", {3'b0, sk_any}, 4'd0);
        chk("R1 so after first shift", {3'b0, so_m}, 4'd0);
        run_cyc(1'b0, 1'b0, 4'h0, 1'b0, 4);
        run_cyc(1'b0, 1'b0, 4'h0, 1'b0, 4);
        chk("R1 so after third shift", {3'b0, so_m}, 4'd0);
        run_cyc(1'b0, 1'b0, 4'h0, 1'b0, 4);
        chk("R1 so after fourth shift", {3'b0, so_m}, 4'd1);

        // priming exchange: register 1000 shifts to 0000, then loads A
        run_cyc(1'b0, 1'b1, 4'hA, 1'b1, 4);
        chk("R3 rd_out from priming exchange", rd_m, 4'h0);
        chk("R3 so shows acc bit 3", {3'b0, so_m}, 4'd1);
        prev = 4'hA;

        // R8: exhaustive sweep of SI patterns and accumulator values
        for (int i = 0; i < 256; i++) begin
            pat = 4'(i);
            nxt = 4'(i >> 4);
            for (int k = 1; k <= 4; k++) begin
                run_cyc(pat[4-k], k == 4, nxt, 1'b1, 4);
                chk("R5 sk high after cycle start", {3'b0, sk_s}, 4'd1);
                chk("R5 sk low after midpoint", {3'b0, sk_m}, 4'd0);
                if (k < 4) chk("R2 so streams loaded bits", {3'b0, so_m}, {3'b0, prev[3-k]});
                else       chk("R3 so shows new acc bit 3", {3'b0, so_m}, {3'b0, nxt[3]});
            end
            chk("R8 readback of streamed bits", rd_m, pat);
            prev = nxt;
        end

        // R2: output enable low forces so low at once and at the midpoint
        so_en = 1'b0;
        #1;
        chk("R2 so gated low immediately", {3'b0, so}, 4'd0);
        run_cyc(1'b0, 1'b0, 4'h0, 1'b1, 4);
        chk("R2 so gated low at midpoint", {3'b0, so_m}, 4'd0);
        so_en = 1'b1;

        // R5: exchange with carry 0 stops the clock. Register F, 2 shifts -> C
        run_cyc(1'b0, 1'b1, 4'h3, 1'b0, 4);
        chk("R3 rd_out after stop exchange", rd_m, 4'hC);
        run_cyc(1'b0, 1'b0, 4'h0, 1'b0, 4);
        chk("R5 no sk pulse after carry 0", {3'b0, sk_any}, 4'd0);

        // R4: exchange off the midpoint ignored (register 3 -> 6 -> C -> 8)
        run_cyc(1'b0, 1'b1, 4'hF, 1'b1, 2);
        chk("R4 rd_out unchanged", rd_m, 4'hC);
        run_cyc(1'b0, 1'b1, 4'h0, 1'b1, 4);
        chk("R4 latch not set by ignored exchange", {3'b0, sk_s}, 4'd0);
        chk("R4 register not loaded by ignored exchange", rd_m, 4'h8);

        // count mode: latch set, register loaded with E
        mode_cnt = 1'b1;
        run_cyc(1'b0, 1'b1, 4'hE, 1'b1, 4);
        chk("R9 count mode does not shift", rd_m, 4'h0);
        for (int j = 0; j < 6; j++) begin
            run_cyc((j % 2) == 0, 1'b0, 4'h0, 1'b1, 4);
            chk("R6 sk steady high in count mode", {3'b0, sk_all}, 4'd1);
        end
        run_cyc(1'b0, 1'b1, 4'h0, 1'b0, 4);
        chk("R9 three falls wrap E to 1", rd_m, 4'h1);
        run_cyc(1'b0, 1'b0, 4'h0, 1'b0, 4);
        chk("R6 sk steady low with latch clear", {3'b0, sk_any}, 4'd0);
        run_cyc(1'b0, 1'b1, 4'h0, 1'b1, 4);
        run_cyc(1'b0, 1'b0, 4'h0, 1'b1, 4);
        chk("R6 sk high again after carry 1", {3'b0, sk_all}, 4'd1);

        // R7: back to shift mode, pulses resume with no exchange
        mode_cnt = 1'b0;
        run_cyc(1'b0, 1'b0, 4'h0, 1'b1, 4);
        chk("R7 sk low at midpoint after switch", {3'b0, sk_m}, 4'd0);
        run_cyc(1'b0, 1'b0, 4'h0, 1'b1, 4);
        chk("R7 sk rises at next cycle start", {3'b0, sk_s}, 4'd1);
        chk("R7 sk falls at next midpoint", {3'b0, sk_m}, 4'd0);

        // R10: reset in mid-stream
        cyc_start = 1'b1;
        step();
        cyc_start = 1'b0;
        rst = 1'b1;
        step();
        chk("R10 sk cleared", {3'b0, sk}, 4'd0);
        chk("R10 so cleared", {3'b0, so}, 4'd0);
        chk("R10 rd_out cleared", rd_out, 4'd0);
        rst = 1'b0;
        run_cyc(1'b0, 1'b0, 4'h0, 1'b1, 4);
        chk("R10 latch cleared", {3'b0, sk_any}, 4'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule